// File: doc/BRIEF.md
# Paired Half-Word Settings Bridge

The bridge joins a 16-bit, byte-addressed control bus to a downstream settings bus. It combines two 16-bit writes into one 32-bit register update. Its address window covers two neighbouring 128-byte slave slots. Inside that window there are 64 write-only settings registers, one every four bytes.

A 32-bit value is written in two steps, in a fixed order:
- The low half-word goes to the register's even word address (offset bits 1:0 = 00). The bridge holds it in a staging register.
- The high half-word then goes to the odd word address (offset bits 1:0 = 10). That write commits the value.

On commit, the bridge raises a one-cycle settings strobe. The strobe carries the register index and the assembled data {high, staged low}. Nothing written can be read back. A read in the window is acknowledged and returns zero.

The bus handshake is a plain strobe and acknowledge. The master holds its strobe until it sees the acknowledge. The bridge accepts an access on a clock edge where the strobe is high, the address is in the window and the acknowledge is low. It acknowledges one cycle later.

Top module: `setting_word_bridge`

## Requirements
- R1: After reset, bus_ack_o and set_stb_o are 0, set_idx_o and set_dat_o are 0, and the staging register is 0. So a commit with no earlier low write carries 0x0000 in bits 15:0.
- R2: The window runs from BASE_SLOT<<7 to (BASE_SLOT<<7)+255. With the defaults this is byte address 1024 up to but not including 1280. An access outside it is never acknowledged and never strobes.
- R3: An accepted access makes bus_ack_o high in the next cycle, for exactly one cycle. While bus_ack_o is high, no new access is accepted.
- R4: A write with offset bit 1 = 0 loads bus_dat_i into the staging register, is acknowledged, and raises no settings strobe.
- R5: A write with offset bit 1 = 1 raises set_stb_o for one cycle, in the same cycle as its acknowledge. In that cycle set_idx_o = (address − window base) >> 2 and set_dat_o = {bus_dat_i, staged half-word}.
- R6: All 64 indices 0..63, across both slots, can be reached. Bits 7:6 of set_idx_o are always 0.
- R7: A high-half write with no fresh low write still commits. It uses the staged half-word, which stays unchanged after a commit.
- R8: Reads in the window are acknowledged with bus_dat_o = 0. They leave the staging register unchanged and raise no strobe.
- R9: When two low writes arrive in a row, the second one's data is the value used by the next commit.
- R10: set_idx_o and set_dat_o keep their values in every cycle without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb_i | input | 1 | Bus access strobe, held until acknowledge |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | ADDR_W (11) | Byte address |
| bus_dat_i | input | HALF_W (16) | Write data |
| bus_dat_o | output | HALF_W (16) | Read data, always zero |
| bus_ack_o | output | 1 | Acknowledge, one cycle |
| set_stb_o | output | 1 | Settings write strobe, one cycle |
| set_idx_o | output | IDX_W (8) | Settings register index |
| set_dat_o | output | 2*HALF_W (32) | Settings register data |

## Verification
The bench sweeps all 64 registers, each with its own computed data. This catches an index taken from the wrong address bits, which would strobe a shifted or aliased index. It also catches a swapped half-word order, which would put the staged value on top.

The bench probes the addresses just outside both window edges. A decoder that is off by one slot would acknowledge them, or miss the first or last register.

Several cases go after the staging register:
- A high write straight after reset, and a high write with no fresh low write. A design that cleared or re-captured the staged value would show the wrong bits 15:0.
- Two low writes in a row. A design that kept the first one would fail here.
- Reads between writes. A design that let a read disturb the staging register or fire the strobe would fail here.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/swb_decode.sv
module swb_decode
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned SLOT_SHIFT = 7,
  parameter int unsigned BASE_SLOT  = 8,
  parameter int unsigned IDX_W      = 8
) (
  input  logic [ADDR_W-1:0] adr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output half_sel_e         half
);
  localparam int unsigned WIN_BASE = BASE_SLOT << SLOT_SHIFT;
  localparam int unsigned WIN_SPAN = 2 << SLOT_SHIFT;

  logic [ADDR_W:0] ofs;

  // Wrap-around makes addresses below the base look huge, so one compare suffices.
  assign ofs  = {1'b0, adr} - (ADDR_W+1)'(WIN_BASE);
  assign hit  = ofs < (ADDR_W+1)'(WIN_SPAN);
  assign idx  = IDX_W'(ofs[SLOT_SHIFT:2]);
  assign half = half_sel_e'(ofs[1]);
endmodule

// File: rtl/swb_stage.sv
module swb_stage #(
  parameter int unsigned HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HALF_W-1:0] din,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/swb_commit.sv
module swb_commit #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [IDX_W-1:0]    idx_in,
  input  logic [HALF_W-1:0]   hi_in,
  input  logic [HALF_W-1:0]   lo_in,
  output logic                stb_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [2*HALF_W-1:0] dat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb_o <= 1'b0;
      idx_o <= '0;
      dat_o <= '0;
    end else begin
      stb_o <= fire;
      if (fire) begin
        idx_o <= idx_in;
        dat_o <= {hi_in, lo_in};
      end
    end
  end
endmodule

// File: rtl/setting_word_bridge.sv
module setting_word_bridge
  import swb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned SLOT_SHIFT = 7,
  parameter int unsigned BASE_SLOT  = 8,
  parameter int unsigned IDX_W      = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_stb_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_adr_i,
  input  logic [HALF_W-1:0]   bus_dat_i,
  output logic [HALF_W-1:0]   bus_dat_o,
  output logic                bus_ack_o,
  output logic                set_stb_o,
  output logic [IDX_W-1:0]    set_idx_o,
  output logic [2*HALF_W-1:0] set_dat_o
);
  logic             hit;
  logic [IDX_W-1:0] dec_idx;
  half_sel_e        dec_half;
  logic             accept;
  logic             ack_q;
  logic [HALF_W-1:0] staged;

  swb_decode #(
    .ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT),
    .BASE_SLOT(BASE_SLOT), .IDX_W(IDX_W)
  ) u_decode (
    .adr(bus_adr_i), .hit(hit), .idx(dec_idx), .half(dec_half)
  );

  assign accept = bus_stb_i && hit && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else     ack_q <= accept;
  end

  swb_stage #(.HALF_W(HALF_W)) u_stage (
    .clk(clk), .rst(rst),
    .load(accept && bus_we_i && dec_half == HALF_LO),
    .din(bus_dat_i), .q(staged)
  );

  swb_commit #(.HALF_W(HALF_W), .IDX_W(IDX_W)) u_commit (
    .clk(clk), .rst(rst),
    .fire(accept && bus_we_i && dec_half == HALF_HI),
    .idx_in(dec_idx), .hi_in(bus_dat_i), .lo_in(staged),
    .stb_o(set_stb_o), .idx_o(set_idx_o), .dat_o(set_dat_o)
  );

  assign bus_ack_o = ack_q;
  assign bus_dat_o = '0;
endmodule

// File: rtl/setting_word_bridge_chk.sv
module setting_word_bridge_chk #(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned SLOT_SHIFT = 7,
  parameter int unsigned BASE_SLOT  = 8,
  parameter int unsigned IDX_W      = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_stb_i,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_adr_i,
  input logic [HALF_W-1:0]   bus_dat_i,
  input logic [HALF_W-1:0]   bus_dat_o,
  input logic                bus_ack_o,
  input logic                set_stb_o,
  input logic [IDX_W-1:0]    set_idx_o,
  input logic [2*HALF_W-1:0] set_dat_o
);
  localparam int unsigned LO_EDGE = BASE_SLOT << SLOT_SHIFT;
  localparam int unsigned HI_EDGE = LO_EDGE + (2 << SLOT_SHIFT);

  logic in_win, taken, commit;
  logic [IDX_W-1:0] exp_idx;
  assign in_win  = (int'(bus_adr_i) >= int'(LO_EDGE)) && (int'(bus_adr_i) < int'(HI_EDGE));
  assign taken   = bus_stb_i && in_win && !bus_ack_o;
  assign commit  = taken && bus_we_i && bus_adr_i[1];
  assign exp_idx = IDX_W'((int'(bus_adr_i) - int'(LO_EDGE)) / 4);

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst) taken |=> bus_ack_o);   // R3
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (rst) !taken |=> !bus_ack_o); // R2
  AST_COMMIT_WORD: assert property (@(posedge clk) disable iff (rst)
    commit |=> set_stb_o && set_idx_o == $past(exp_idx) && set_dat_o[2*HALF_W-1:HALF_W] == $past(bus_dat_i)); // R5
  AST_NO_STRAY_STB: assert property (@(posedge clk) disable iff (rst) !commit |=> !set_stb_o); // R4
  AST_READ_ZERO: assert property (@(posedge clk) disable iff (rst) bus_ack_o |-> bus_dat_o == '0); // R8
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(set_idx_o) && $stable(set_dat_o)); // R10
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    set_stb_o |-> int'(set_idx_o) < ((2 << SLOT_SHIFT) / 4)); // R6
endmodule

bind setting_word_bridge setting_word_bridge_chk #(
  .ADDR_W(ADDR_W), .HALF_W(HALF_W), .SLOT_SHIFT(SLOT_SHIFT),
  .BASE_SLOT(BASE_SLOT), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_stb_i(bus_stb_i), .bus_we_i(bus_we_i),
  .bus_adr_i(bus_adr_i), .bus_dat_i(bus_dat_i), .bus_dat_o(bus_dat_o),
  .bus_ack_o(bus_ack_o), .set_stb_o(set_stb_o), .set_idx_o(set_idx_o),
  .set_dat_o(set_dat_o)
);

// File: tb/setting_word_bridge_test.sv
module setting_word_bridge_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_stb_i = 1'b0, bus_we_i = 1'b0;
  logic [10:0] bus_adr_i = '0;
  logic [15:0] bus_dat_i = '0;
  logic [15:0] bus_dat_o;
  logic bus_ack_o, set_stb_o;
  logic [7:0] set_idx_o;
  logic [31:0] set_dat_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  setting_word_bridge uut (
    .clk(clk), .rst(rst), .bus_stb_i(bus_stb_i), .bus_we_i(bus_we_i),
    .bus_adr_i(bus_adr_i), .bus_dat_i(bus_dat_i), .bus_dat_o(bus_dat_o),
    .bus_ack_o(bus_ack_o), .set_stb_o(set_stb_o), .set_idx_o(set_idx_o),
    .set_dat_o(set_dat_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus access; reports ack seen, strobe seen with that ack, and captured outputs.
  task automatic access(input logic we, input int adr, input logic [15:0] dat,
                        output logic got_ack, output logic got_stb,
                        output logic [7:0] idx, output logic [31:0] sdat,
                        output logic [15:0] rdat);
    got_ack = 1'b0; got_stb = 1'b0; idx = '0; sdat = '0; rdat = '0;
    @(negedge clk);
    bus_stb_i = 1'b1; bus_we_i = we; bus_adr_i = 11'(adr); bus_dat_i = dat;
    for (int k = 0; k < 3 && !got_ack; k++) begin
      @(negedge clk);
      if (set_stb_o) got_stb = 1'b1;
      if (bus_ack_o) begin
        got_ack = 1'b1; idx = set_idx_o; sdat = set_dat_o; rdat = bus_dat_o;
      end
    end
    bus_stb_i = 1'b0; bus_we_i = 1'b0;
    @(negedge clk);
    if (set_stb_o) got_stb = 1'b1;
  endtask

  initial begin
    logic a, s;
    logic [7:0] ix;
    logic [31:0] d;
    logic [15:0] r;
    logic [7:0] hold_idx;
    logic [31:0] hold_dat;
    repeat (3) @(negedge clk);
    check("R1 ack", 32'(bus_ack_o), 0);
    check("R1 stb", 32'(set_stb_o), 0);
    check("R1 idx", 32'(set_idx_o), 0);
    check("R1 dat", set_dat_o, 0);
    rst = 1'b0;

    // High half first after reset: staged low must be zero
    access(1'b1, BASE + 4*9 + 2, 16'hBEEF, a, s, ix, d, r);
    check("R1 staged zero", d, 32'hBEEF0000);
    check("R5 idx", 32'(ix), 9);

    // Full sweep of all 64 registers
    for (int n = 0; n < 64; n++) begin
      logic [15:0] lo, hi;
      lo = 16'(16'h1000 + n * 37);
      hi = 16'hC000 ^ 16'(n << 4);
      access(1'b1, BASE + 4*n, lo, a, s, ix, d, r);
      check("R4 low ack", 32'(a), 1);
      check("R4 low no strobe", 32'(s), 0);
      access(1'b1, BASE + 4*n + 2, hi, a, s, ix, d, r);
      check("R5 high strobe", 32'({a, s}), 32'b11);
      check("R6 index", 32'(ix), 32'(n));
      check("R5 data", d, {hi, lo});
    end

    // Window edges
    access(1'b1, BASE - 2, 16'h1111, a, s, ix, d, r);
    check("R2 below base", 32'({a, s}), 0);
    access(1'b1, BASE + 256, 16'h2222, a, s, ix, d, r);
    check("R2 above top", 32'({a, s}), 0);
    access(1'b1, 2, 16'h3333, a, s, ix, d, r);
    check("R2 far away", 32'({a, s}), 0);
    access(1'b1, BASE + 254, 16'h4444, a, s, ix, d, r);
    check("R2 last word", 32'({a, s}), 32'b11);
    check("R6 last index", 32'(ix), 63);

    // Orphan high write reuses staged (last low was reg 63: 0x1000+63*37)
    access(1'b1, BASE + 4*5 + 2, 16'h5A5A, a, s, ix, d, r);
    check("R7 orphan high", d, {16'h5A5A, 16'(16'h1000 + 63*37)});

    // Reads: zero data, no strobe, staging untouched
    access(1'b1, BASE + 4*7, 16'hABCD, a, s, ix, d, r);
    access(1'b0, BASE + 4*7, 16'h0000, a, s, ix, d, r);
    check("R8 read ack", 32'(a), 1);
    check("R8 read zero", 32'(r), 0);
    check("R8 read no strobe", 32'(s), 0);
    access(1'b0, BASE + 4*7 + 2, 16'h0000, a, s, ix, d, r);
    check("R8 read high no strobe", 32'({a, s}), 32'b10);
    access(1'b1, BASE + 4*7 + 2, 16'h7777, a, s, ix, d, r);
    check("R8 staging kept", d, 32'h7777ABCD);

    // Latest low wins
    access(1'b1, BASE + 4*20, 16'h0101, a, s, ix, d, r);
    access(1'b1, BASE + 4*21, 16'h0202, a, s, ix, d, r);
    access(1'b1, BASE + 4*20 + 2, 16'h0303, a, s, ix, d, r);
    check("R9 latest low", d, 32'h03030202);
    check("R9 idx", 32'(ix), 20);

    // Hold and single-cycle behaviour
    hold_idx = set_idx_o; hold_dat = set_dat_o;
    repeat (4) @(negedge clk);
    check("R10 idx hold", 32'(set_idx_o), 32'(hold_idx));
    check("R10 dat hold", set_dat_o, hold_dat);
    check("R3 ack cleared", 32'(bus_ack_o), 0);
    check("R5 strobe cleared", 32'(set_stb_o), 0);

    // Held strobe: ack must drop the cycle after it rises
    @(negedge clk);
    bus_stb_i = 1'b1; bus_we_i = 1'b0; bus_adr_i = 11'(BASE);
    @(negedge clk);
    check("R3 ack rises", 32'(bus_ack_o), 1);
    @(negedge clk);
    check("R3 ack one cycle", 32'(bus_ack_o), 0);
    bus_stb_i = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1'b1;
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule